// File: doc/BRIEF.md
# Spike-Encoded Threshold NAND/NOR Gate

This block evaluates an N-input NAND or NOR function where every Boolean value travels as an event on a two-bit channel. In any clock step a channel is idle, carries a spike (logic 1) or carries an anti-spike (logic 0). Each input feeds its own relay stage. The relay turns a spike into two counting units and an anti-spike into one unit. A single output cell adds up every unit delivered in a step and compares the total with fixed thresholds. From that comparison it emits a spike, an anti-spike or nothing.

A parameter selects the gate flavour. In NAND mode only the full count of 2N units gives an anti-spike. In NOR mode only the minimum valid count of N units gives a spike. Each evaluation applies all of its inputs in the same step. The output cell keeps nothing from one step to the next, so the block accepts a new input set every cycle and returns each result exactly three steps later.

Top module: `spk_gate`

## Requirements
- R1: Each channel uses the code 00 for idle, 01 for spike (logic 1) and 10 for anti-spike (logic 0). The output channel never shows 11. An input of 11 is illegal and is flagged by an assertion.
- R2: A spike input adds 2 units to the step's count, an anti-spike adds 1 and an idle input adds 0. The count never exceeds 2N.
- R3: In NAND mode, a count of exactly 2N emits an anti-spike (10), and a count from N to 2N-1 emits a spike (01).
- R4: In NOR mode, a count of exactly N emits a spike (01), and a count from N+1 to 2N emits an anti-spike (10).
- R5: A count below N, for example with all inputs idle, leaves the output idle (00).
- R6: The result for an input set applied in one step appears at the output three clock steps later. Input sets in consecutive steps give independent results with no carry-over.
- R7: While the synchronous active-low reset is asserted, the output is idle, and the results of inputs applied during reset never appear.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| in_ch | input | 2*N_IN | N_IN two-bit input channels; channel i occupies bits [2i+1:2i] |
| out_ch | output | 2 | Two-bit output channel |

## Verification
A wrong unit count in a relay, or a wrong threshold in the output cell, shows up as the wrong event on out_ch exactly three steps after the affected input set. The error is plainest at the boundary counts N, N+1, 2N-1 and 2N. A count register that kept stale units would corrupt the result of the following step. Back-to-back input sets with opposite results expose that one step later. A reset that fails to clear the pipeline shows within the first three steps after release, as a non-idle output where idle is expected.

// File: rtl/spk_pkg.sv
// Shared channel codes and gate mode for the spike-encoded gate.
// Assumes a two-bit channel; code 11 is never legal on any port.
package spk_pkg;

    typedef enum logic [1:0] {
        CH_IDLE = 2'b00,
        CH_POS  = 2'b01,
        CH_NEG  = 2'b10,
        CH_BAD  = 2'b11
    } chan_t;

    typedef enum logic {
        GATE_NAND = 1'b0,
        GATE_NOR  = 1'b1
    } gate_t;

    // Units a relay forwards for one channel code (illegal code counts as idle).
    function automatic logic [1:0] units_of(input logic [1:0] code);
        case (code)
            CH_POS:  units_of = 2'd2;
            CH_NEG:  units_of = 2'd1;
            default: units_of = 2'd0;
        endcase
    endfunction

endpackage

// File: rtl/spk_relay.sv
// Relay stage: registers one input channel as a unit count for the output cell.
// Assumes synchronous active-low reset; adds one step of latency.
module spk_relay
    import spk_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] ch,
    output logic [1:0] units
);

    // Convert the incoming event into 0, 1 or 2 units for the next step.
    always_ff @(posedge clk) begin
        if (!rst_n) units <= 2'd0;
        else        units <= units_of(ch);
    end

    AST_IN_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        ch != CH_BAD); // R1

endmodule

// File: rtl/spk_cell.sv
// Counting output cell: sums the relay units of a step, then fires on thresholds.
// Assumes all inputs of an evaluation arrive in the same step; the count is
// replaced every step, so no state carries from one evaluation to the next.
module spk_cell
    import spk_pkg::*;
#(
    parameter int    N_IN = 4,
    parameter gate_t MODE = GATE_NAND,
    parameter int    CW   = $clog2(2*N_IN+1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [2*N_IN-1:0]  units_all,
    output logic [1:0]         out_ch
);

    localparam int LO = N_IN;
    localparam int HI = 2*N_IN;

    logic [CW-1:0] sum_c;
    logic [CW-1:0] count_q;
    logic [1:0]    fire_c;

    // Add the units of all relays for the current step.
    always_comb begin
        sum_c = '0;
        for (int i = 0; i < N_IN; i++) begin
            sum_c = sum_c + CW'(units_all[2*i +: 2]);
        end
    end

    // Hold the step's count; it is overwritten every cycle, which clears it.
    always_ff @(posedge clk) begin
        if (!rst_n) count_q <= '0;
        else        count_q <= sum_c;
    end

    // Choose the output event from the held count and the gate mode.
    always_comb begin
        if (int'(count_q) < LO) begin
            fire_c = CH_IDLE;
        end else if (MODE == GATE_NAND) begin
            fire_c = (int'(count_q) == HI) ? CH_NEG : CH_POS;
        end else begin
            fire_c = (int'(count_q) == LO) ? CH_POS : CH_NEG;
        end
    end

    // Register the emitted event onto the output channel.
    always_ff @(posedge clk) begin
        if (!rst_n) out_ch <= CH_IDLE;
        else        out_ch <= fire_c;
    end

    AST_OUT_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        out_ch != CH_BAD); // R1
    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        int'(count_q) <= HI); // R2
    AST_BELOW_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(count_q) < LO) |=> (out_ch == CH_IDLE)); // R5
    AST_NAND_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        (MODE == GATE_NAND && int'(count_q) == HI) |=> (out_ch == CH_NEG)); // R3
    AST_NOR_MIN: assert property (@(posedge clk) disable iff (!rst_n)
        (MODE == GATE_NOR && int'(count_q) == LO) |=> (out_ch == CH_POS)); // R4

endmodule

// File: rtl/spk_gate.sv
// Top of the spike-encoded threshold gate: one relay per input, one counting cell.
// Assumes N_IN in 2..8 and legal channel codes; latency is three clock steps.
module spk_gate
    import spk_pkg::*;
#(
    parameter int    N_IN = 4,
    parameter gate_t MODE = GATE_NAND
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [2*N_IN-1:0] in_ch,
    output logic [1:0]        out_ch
);

    localparam int CW = $clog2(2*N_IN+1);

    logic [2*N_IN-1:0] units_all;

    // One relay stage per input channel.
    for (genvar g = 0; g < N_IN; g++) begin : g_relay
        spk_relay u_relay (
            .clk   (clk),
            .rst_n (rst_n),
            .ch    (in_ch[2*g +: 2]),
            .units (units_all[2*g +: 2])
        );
    end

    spk_cell #(.N_IN(N_IN), .MODE(MODE), .CW(CW)) u_cell (
        .clk       (clk),
        .rst_n     (rst_n),
        .units_all (units_all),
        .out_ch    (out_ch)
    );

    initial begin
        assert (N_IN >= 2 && N_IN <= 8); // R2
    end

endmodule

// File: tb/tb_spk_gate.sv
// Bench: drives a NAND and a NOR instance with the same channels and checks
// each result three steps later against a model computed from the requirements.
module tb_spk_gate;
    import spk_pkg::*;

    localparam int N = 4;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic [2*N-1:0] in_ch = '0;
    logic [1:0]     out_nand;
    logic [1:0]     out_nor;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    logic [1:0] hist_nand [3];
    logic [1:0] hist_nor  [3];
    logic       hist_v    [3];

    always #2 clk = ~clk;

    spk_gate #(.N_IN(N), .MODE(GATE_NAND)) dut (
        .clk(clk), .rst_n(rst_n), .in_ch(in_ch), .out_ch(out_nand));
    spk_gate #(.N_IN(N), .MODE(GATE_NOR)) dut_nor (
        .clk(clk), .rst_n(rst_n), .in_ch(in_ch), .out_ch(out_nor));

    // R2: the count is 2 units per spike and 1 per anti-spike.
    function automatic int model_count(input logic [2*N-1:0] v);
        int c = 0;
        for (int i = 0; i < N; i++) begin
            if (v[2*i +: 2] == 2'b01) c += 2;
            else if (v[2*i +: 2] == 2'b10) c += 1;
        end
        return c;
    endfunction

    // R3, R4 and R5: threshold rules per mode.
    function automatic logic [1:0] model_out(input logic [2*N-1:0] v, input bit nor_mode);
        int c = model_count(v);
        if (c < N) return 2'b00;
        if (!nor_mode) return (c == 2*N) ? 2'b10 : 2'b01;
        return (c == N) ? 2'b01 : 2'b10;
    endfunction

    task automatic check(input string req, input logic [1:0] act, input logic [1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%b expected=%b", req, act, exp);
        end
    endtask

    // One step: check the result due now, then drive the next input set.
    task automatic step(input logic [2*N-1:0] v, input string req);
        @(negedge clk);
        if (hist_v[2]) begin
            check(req, out_nand, hist_nand[2]);
            check(req, out_nor, hist_nor[2]);
        end
        check("R1", {out_nand == 2'b11, out_nor == 2'b11}, 2'b00);
        hist_nand[2] = hist_nand[1]; hist_nor[2] = hist_nor[1]; hist_v[2] = hist_v[1];
        hist_nand[1] = hist_nand[0]; hist_nor[1] = hist_nor[0]; hist_v[1] = hist_v[0];
        hist_nand[0] = model_out(v, 1'b0);
        hist_nor[0]  = model_out(v, 1'b1);
        hist_v[0]    = 1'b1;
        in_ch = v;
    endtask

    function automatic logic [2*N-1:0] rand_vec(input bit all_valid);
        logic [2*N-1:0] v;
        for (int i = 0; i < N; i++) begin
            int r = int'($urandom % 8);
            if (all_valid) v[2*i +: 2] = (r < 4) ? 2'b01 : 2'b10;
            else v[2*i +: 2] = (r < 2) ? 2'b00 : ((r < 5) ? 2'b01 : 2'b10);
        end
        return v;
    endfunction

    function automatic logic [2*N-1:0] fill(input logic [1:0] code);
        logic [2*N-1:0] v;
        for (int i = 0; i < N; i++) v[2*i +: 2] = code;
        return v;
    endfunction

    // Watchdog: a hung run counts as a failure and still reports.
    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            errors++;
            $display("FAIL watchdog actual=%0d expected<=100000", cycles);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [2*N-1:0] v;
        void'($urandom(32'd2718));
        for (int i = 0; i < 3; i++) hist_v[i] = 1'b0;
        // R7: inputs during reset must not reach the output.
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            in_ch = fill(2'b01);
        end
        @(negedge clk);
        check("R7", out_nand, 2'b00);
        check("R7", out_nor, 2'b00);
        in_ch = fill(2'b00);
        rst_n = 1'b1;
        @(negedge clk);
        @(negedge clk);
        check("R7", out_nand, 2'b00);
        check("R7", out_nor, 2'b00);

        // R3/R4 boundary counts, back to back for R6.
        step(fill(2'b01), "R3");                  // 2N
        step(fill(2'b10), "R4");                  // N
        v = fill(2'b01); v[1:0] = 2'b10;
        step(v, "R3");                            // 2N-1
        v = fill(2'b10); v[1:0] = 2'b01;
        step(v, "R4");                            // N+1
        step(fill(2'b00), "R5");                  // 0
        v = fill(2'b00); v[1:0] = 2'b10;
        step(v, "R5");                            // 1
        step(fill(2'b01), "R6");
        step(fill(2'b10), "R6");
        step(fill(2'b01), "R6");
        // R2: mixed idle and valid inputs, then fully valid random sets.
        for (int i = 0; i < 300; i++) step(rand_vec(1'b0), "R2");
        for (int i = 0; i < 300; i++) step(rand_vec(1'b1), "R6");
        // Flush the pipeline.
        for (int i = 0; i < 3; i++) step(fill(2'b00), "R5");

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule